// File: doc/BRIEF.md
# Bit-serial ones counter

The block counts how many bits of an input vector are set by examining one bit per clock. A start strobe captures the vector, clears an index register and a count register, and moves the controller into a scanning state. In each scanning cycle the index picks one bit of the captured vector. The count increments when that bit is one and holds when it is zero. The index advances in every scanning cycle, whatever the bit's value.

The count is held in toggle flip-flops. Bit 0 toggles on a set input bit. Each higher bit toggles on a set input bit when every lower count bit is one. The count output is the count register ANDed with a decode of the terminal index value, which equals the vector width `N_BITS`. The output therefore reads zero while a scan is under way. It shows the total from the cycle in which the index reaches its terminal value, and a one-cycle done pulse marks that cycle. The result stays visible until the next start.

The controller has three states. IDLE waits. SCAN examines one bit per cycle. FINISH lasts one cycle and raises done. The transitions are:
- IDLE to SCAN on start.
- SCAN to FINISH when the last bit is examined.
- FINISH to IDLE unconditionally.
- Any state to SCAN on start, which restarts the operation.

Width 7 gives a 7:3 counter whose output opens at index binary 111. Width 5 gives a 5:3 counter that opens at binary 101.

Top module: `serial_ones_counter`

## Requirements
- R1: With the synchronous reset `rst` high at a clock edge, `count_o` and `done_o` read 0 after that edge. A scan cut short by reset never raises `done_o`.
- R2: When `start_i` is sampled at edge k, `done_o` is high exactly between edges k+N_BITS and k+N_BITS+1. The index advances one position per cycle regardless of the bit value.
- R3: In the done cycle, `count_o` equals the number of ones in the vector captured with the start. The count increments on a one and holds on a zero.
- R4: A start clears the count and the index and captures `vec_i`. `count_o` reads 0 in the cycle after a start, even when an earlier result was on display.
- R5: While the index is below `N_BITS`, that is during a scan, `count_o` reads 0 and `done_o` is low.
- R6: `done_o` is a single-cycle pulse. After it, `count_o` keeps showing the result until the next start.
- R7: A start during a scan restarts with the newly presented vector. The interrupted scan produces no done pulse and no result.
- R8: The count register holds values up to `N_BITS`, so an all-ones vector reads `N_BITS`. With `N_BITS` = 5, the output opens at index 5 and the done pulse follows the start by 5 cycles.
- R9: A start presented in the done cycle begins a new scan at once. Its result follows `N_BITS` cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load strobe; captures `vec_i` and starts a scan |
| vec_i | input | N_BITS | Vector whose set bits are counted |
| count_o | output | $clog2(N_BITS+1) | Number of ones, gated to zero until the scan ends |
| done_o | output | 1 | One-cycle pulse marking a valid `count_o` |

## Verification
The 7-bit instance is driven with these vectors:
- All zeros and all ones, which check the two ends of the count range and the widest toggle carry.
- Alternating patterns, which show that the index steps on zero bits as well as on one bits.
- A lone one at either end, which checks that the first and the last scanned positions are both counted.
- Irregular mixes, which check the gated increment under changing input.

A 5-bit instance repeats part of this set to check the other terminal decode and the shorter latency. Directed sequences then cover three cases: a restart in the middle of a scan (the old total must never appear), a start placed in the done cycle, and a reset that cuts a scan short.

// File: rtl/serial_ones_pkg.sv
package serial_ones_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } scan_state_e;

endpackage

// File: rtl/sones_index_seq.sv
module sones_index_seq #(
    parameter int N_BITS = 7,
    parameter int IDX_W  = $clog2(N_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o,
    output logic             term_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BITS - 1);
    localparam logic [IDX_W-1:0] TERM_IDX = IDX_W'(N_BITS);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LAST_IDX);
    assign term_o = (idx_q == TERM_IDX);

    // R2: one position per scanning cycle
    a_r2_idx_step: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !clr_i) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

    // R4: a start returns the index to zero
    a_r4_idx_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (idx_q == '0));

    // R2: the index never runs past its terminal value
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (rst)
        (idx_q <= TERM_IDX));

endmodule

// File: rtl/sones_toggle_count.sv
module sones_toggle_count #(
    parameter int N_BITS = 7,
    parameter int CNT_W  = $clog2(N_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lower_ones;
    logic [CNT_W-1:0] flip;

    for (genvar g = 0; g < CNT_W; g++) begin : g_tff
        if (g == 0) begin : g_lsb
            assign lower_ones[g] = 1'b1;
        end else begin : g_upper
            assign lower_ones[g] = lower_ones[g-1] & cnt_q[g-1];
        end

        assign flip[g] = en_i & bit_i & lower_ones[g];

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                cnt_q[g] <= 1'b0;
            end else if (flip[g]) begin
                cnt_q[g] <= ~cnt_q[g];
            end
        end
    end

    assign cnt_o = cnt_q;

    // R3: increment on a one, hold on a zero
    a_r3_gated_inc: assert property (@(posedge clk) disable iff (rst)
        (en_i && !clr_i) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'($past(bit_i)))));

    // R8: the count never exceeds the vector width
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_q) <= N_BITS));

    // R4: a start clears the count
    a_r4_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/sones_out_gate.sv
module sones_out_gate #(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             open_i,
    output logic [CNT_W-1:0] count_o
);

    for (genvar g = 0; g < CNT_W; g++) begin : g_and
        assign count_o[g] = cnt_i[g] & open_i;
    end

endmodule

// File: rtl/serial_ones_counter.sv
module serial_ones_counter
    import serial_ones_pkg::*;
#(
    parameter  int N_BITS = 7,
    localparam int CNT_W  = $clog2(N_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [N_BITS-1:0] vec_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              done_o
);

    localparam int IDX_W = $clog2(N_BITS + 1);
    localparam int PAD_W = 1 << IDX_W;

    scan_state_e st_q;
    scan_state_e st_d;

    logic [N_BITS-1:0] vec_q;
    logic [PAD_W-1:0]  vec_pad;
    logic [IDX_W-1:0]  idx;
    logic              idx_last;
    logic              idx_term;
    logic              adv;
    logic              cur_bit;
    logic [CNT_W-1:0]  cnt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d = ST_SCAN;
        end else begin
            unique case (st_q)
                ST_IDLE:   st_d = ST_IDLE;
                ST_SCAN:   st_d = idx_last ? ST_FINISH : ST_SCAN;
                ST_FINISH: st_d = ST_IDLE;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // outputs of the controller
    always_comb begin
        done_o = 1'b0;
        adv    = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_SCAN:   adv = !start_i;
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    // captured vector
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (start_i) begin
            vec_q <= vec_i;
        end
    end

    assign vec_pad = {{(PAD_W - N_BITS){1'b0}}, vec_q};
    assign cur_bit = vec_pad[idx];

    sones_index_seq #(
        .N_BITS (N_BITS),
        .IDX_W  (IDX_W)
    ) u_index (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (start_i),
        .adv_i  (adv),
        .idx_o  (idx),
        .last_o (idx_last),
        .term_o (idx_term)
    );

    sones_toggle_count #(
        .N_BITS (N_BITS),
        .CNT_W  (CNT_W)
    ) u_count (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (start_i),
        .en_i   (adv),
        .bit_i  (cur_bit),
        .cnt_o  (cnt)
    );

    sones_out_gate #(
        .CNT_W (CNT_W)
    ) u_gate (
        .cnt_i   (cnt),
        .open_i  (idx_term),
        .count_o (count_o)
    );

    // R5: no partial count reaches the output during a scan
    a_r5_hidden_while_scan: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SCAN) |-> (count_o == '0 && !done_o));

    // R6: done lasts a single cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: the result holds while idle
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !start_i && $past(!rst)) |=> $stable(count_o));

    // R7: a start is never followed directly by done
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !done_o);

    // R2: done only follows a scan
    a_r2_done_after_scan: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(st_q) == ST_SCAN));

endmodule

// File: tb/serial_ones_counter_tb.sv
`timescale 1ns/1ps
module serial_ones_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start7 = 1'b0;
    logic       start5 = 1'b0;
    logic [6:0] vec7 = '0;
    logic [4:0] vec5 = '0;
    logic [2:0] cnt7;
    logic [2:0] cnt5;
    logic       done7;
    logic       done5;
    logic       use5 = 1'b0;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    serial_ones_counter #(.N_BITS(7)) u_dut (
        .clk (clk), .rst (rst), .start_i (start7), .vec_i (vec7),
        .count_o (cnt7), .done_o (done7)
    );

    serial_ones_counter #(.N_BITS(5)) u_dut5 (
        .clk (clk), .rst (rst), .start_i (start5), .vec_i (vec5),
        .count_o (cnt5), .done_o (done5)
    );

    localparam logic [6:0] VEC7 [8] = '{7'b0000000, 7'b1111111, 7'b1010101, 7'b0101010,
                                        7'b1000000, 7'b0000001, 7'b1100110, 7'b0111011};
    localparam int         EXP7 [8] = '{0, 7, 4, 3, 1, 1, 4, 5};
    localparam logic [4:0] VEC5 [5] = '{5'b00000, 5'b11111, 5'b10110, 5'b00001, 5'b01010};
    localparam int         EXP5 [5] = '{0, 5, 3, 1, 2};

    function automatic int cur_cnt();
        return use5 ? int'(cnt5) : int'(cnt7);
    endfunction

    function automatic bit cur_done();
        return use5 ? done5 : done7;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; start is sampled at the next rising edge
    task automatic kick(input logic [6:0] v);
        if (use5) begin start5 = 1'b1; vec5 = v[4:0]; end
        else      begin start7 = 1'b1; vec7 = v; end
        @(posedge clk);
        @(negedge clk);
        start5 = 1'b0;
        start7 = 1'b0;
    endtask

    task automatic watch(input int exp, input string req);
        int n = use5 ? 5 : 7;
        check(cur_cnt() == 0 && !cur_done(), "R4", cur_cnt(), 0);
        for (int j = 1; j < n; j++) begin
            @(posedge clk);
            @(negedge clk);
            check(cur_cnt() == 0 && !cur_done(), "R5", cur_cnt() + 10 * int'(cur_done()), 0);
        end
        @(posedge clk);
        @(negedge clk);
        check(cur_done(), "R2", int'(cur_done()), 1);
        check(cur_cnt() == exp, req, cur_cnt(), exp);
    endtask

    task automatic hold(input int exp);
        @(posedge clk);
        @(negedge clk);
        check(!cur_done() && cur_cnt() == exp, "R6", cur_cnt() + 10 * int'(cur_done()), exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of both instances
        check(cnt7 == 0 && !done7, "R1", int'(cnt7), 0);
        check(cnt5 == 0 && !done5, "R1", int'(cnt5), 0);
        rst = 1'b0;

        // R3: table of vectors, 7-bit instance
        use5 = 1'b0;
        for (int i = 0; i < 8; i++) begin
            kick(VEC7[i]);
            watch(EXP7[i], "R3");
            hold(EXP7[i]);
        end

        // R8: table of vectors, 5-bit instance
        use5 = 1'b1;
        for (int i = 0; i < 5; i++) begin
            kick({2'b00, VEC5[i]});
            watch(EXP5[i], "R8");
            hold(EXP5[i]);
        end
        use5 = 1'b0;

        // R7: restart in the middle of a scan
        kick(7'b1111111);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done7 && cnt7 == 0, "R7", int'(cnt7), 0);
        kick(7'b0000001);
        watch(1, "R7");
        hold(1);

        // R9: start presented in the done cycle
        kick(7'b1010101);
        watch(4, "R9");
        kick(7'b0101010);
        watch(3, "R9");
        hold(3);

        // R1: reset cuts a scan short
        kick(7'b1111111);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(cnt7 == 0 && !done7, "R1", int'(cnt7), 0);
        for (int j = 0; j < 10; j++) begin
            @(posedge clk);
            @(negedge clk);
            check(cnt7 == 0 && !done7, "R1", int'(cnt7) + 10 * int'(done7), 0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule